// File: doc/BRIEF.md
# Debug Register Lock and Claim-Tag Unit

This block sits on a simple 32-bit register bus in front of a bank of debug registers. It holds eight claim-tag bits that software agents use to mark ownership of debug resources. One register sets these bits and a second register clears them. Each bit changes only where the written word carries a 1.

A write-only key register arms or disarms a write lock. While the lock is armed, writes to the protected registers are dropped. The protected registers are the claim-tag pair and a 32-bit scratch word, which stands in for the rest of the debug bank. The lock comes out of reset armed. A read-only status word reports the lock state, and the `locked` pin drives the same state to the rest of the bank.

Bus reads are combinational: `rd_data` follows `addr` in the same cycle that `rd_en` is high. Writes take effect at the rising clock edge that ends the write cycle. Word addresses are: 0 scratch, 1 claim set, 2 claim clear, 3 key, 4 status. All other addresses are unmapped.

Top module: `dbglk_unit`

## Requirements
- R1: After reset `locked` is 1, the claim tags are 0x00 and the scratch word is 0.
- R2: A write of 0xC5ACCE55 to address 3 clears `locked` at the end of that cycle. A protected write in the very next cycle is accepted.
- R3: A write of any other 32-bit value to address 3 sets `locked` at the end of that cycle.
- R4: While `locked` is 1, writes to addresses 0, 1 and 2 change nothing.
- R5: When unlocked, a write to address 1 sets each claim tag whose data bit in [7:0] is 1. Tags whose data bit is 0 keep their value.
- R6: When unlocked, a write to address 2 clears each claim tag whose data bit in [7:0] is 1. Tags whose data bit is 0 keep their value.
- R7: A read of address 1 always returns 0x000000FF.
- R8: A read of address 2 returns the claim tags in [7:0] and zero in [31:8]. Written bits [31:8] are ignored.
- R9: A read of address 4 returns bit0=1, bit1=`locked`, bit2=0 (32-bit word access), and zero in all other bits. That is 0x3 when locked and 0x1 when unlocked.
- R10: Address 3 reads as 0. Addresses 3 and 4 are usable while locked. Writes to address 4 have no effect.
- R11: Unmapped addresses read as 0 and ignore writes. With `rd_en` low, `rd_data` is 0.
- R12: When unlocked, a write to address 0 stores all 32 bits, and a read of address 0 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| locked | output | 1 | Current lock state, 1 = protected writes dropped |

## Verification
A wrong lock state shows at once on `locked` and in the status word. It also shows within one cycle as a protected write that is kept or dropped when it should not be, and this becomes visible on the next read of the scratch or claim-clear address. A corrupted claim tag stays hidden until the claim-clear register is read, so the bench reads it back after every set and clear pattern. An error in the key comparison shows up the cycle after a near-miss key write, when the status word still reads 0x1.

// File: rtl/dbglk_pkg.sv
package dbglk_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_TAGS = 8;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

  localparam int unsigned A_SCRATCH = 0;
  localparam int unsigned A_TAG_SET = 1;
  localparam int unsigned A_TAG_CLR = 2;
  localparam int unsigned A_KEY     = 3;
  localparam int unsigned A_STATUS  = 4;
endpackage

// File: rtl/dbglk_lock.sv
module dbglk_lock
  import dbglk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked <= 1'b1;
    else if (key_wr) locked <= (key_data != UNLOCK_KEY);
  end
endmodule

// File: rtl/dbglk_claim.sv
module dbglk_claim #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] tags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (set_wr && wbits[i])      tags[i] <= 1'b1;
        else if (clr_wr && wbits[i]) tags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbglk_scratch.sv
module dbglk_scratch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/dbglk_unit.sv
module dbglk_unit
  import dbglk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              locked
);
  localparam int unsigned PAD_W = DATA_W - NUM_TAGS;

  logic hit_scr, hit_set, hit_clr, hit_key, hit_stat;
  logic prot_ok;
  logic [NUM_TAGS-1:0] tags;
  logic [DATA_W-1:0]   scr_q;
  logic [DATA_W-1:0]   mux;

  assign hit_scr  = (addr == ADDR_W'(A_SCRATCH));
  assign hit_set  = (addr == ADDR_W'(A_TAG_SET));
  assign hit_clr  = (addr == ADDR_W'(A_TAG_CLR));
  assign hit_key  = (addr == ADDR_W'(A_KEY));
  assign hit_stat = (addr == ADDR_W'(A_STATUS));
  assign prot_ok  = wr_en && !locked;

  dbglk_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_en && hit_key),
    .key_data (wr_data),
    .locked   (locked)
  );

  dbglk_claim #(.N(NUM_TAGS)) u_claim (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (prot_ok && hit_set),
    .clr_wr (prot_ok && hit_clr),
    .wbits  (wr_data[NUM_TAGS-1:0]),
    .tags   (tags)
  );

  dbglk_scratch #(.W(DATA_W)) u_scratch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (prot_ok && hit_scr),
    .wdata (wr_data),
    .q     (scr_q)
  );

  always_comb begin
    mux = '0;
    if (hit_scr)  mux = scr_q;
    if (hit_set)  mux = {{PAD_W{1'b0}}, {NUM_TAGS{1'b1}}};
    if (hit_clr)  mux = {{PAD_W{1'b0}}, tags};
    if (hit_stat) mux = {{(DATA_W-3){1'b0}}, 1'b0, locked, 1'b1};
  end

  assign rd_data = rd_en ? mux : '0;
endmodule

// File: rtl/dbglk_checker.sv
module dbglk_checker
  import dbglk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              locked
);
  logic key_wr;
  assign key_wr = wr_en && (addr == ADDR_W'(A_KEY));

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && (wr_data == UNLOCK_KEY) |=> !locked);

  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && (wr_data != UNLOCK_KEY) |=> locked);

  assert_lock_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(locked));

  assert_set_reads_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(A_TAG_SET)) |-> rd_data == 32'h0000_00FF);

  assert_clr_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(A_TAG_CLR)) |-> rd_data[31:8] == 24'h0);

  assert_status_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(A_STATUS)) |-> rd_data == (locked ? 32'h3 : 32'h1));

  assert_key_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == ADDR_W'(A_KEY)) |-> rd_data == 32'h0);

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 32'h0);
endmodule

bind dbglk_unit dbglk_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .locked  (locked)
);

// File: tb/dbglk_unit_bench.sv
module dbglk_unit_bench;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int NVEC   = 31;

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [31:0] d;
  } vec_t;

  // rd=1: read and compare d; rd=0: write d
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 4'd4, 32'h0000_0003},  // R9 locked status
    '{1'b0, 4'd0, 32'h0000_1234},  // R4 scratch write while locked
    '{1'b1, 4'd0, 32'h0000_0000},  // R4
    '{1'b0, 4'd1, 32'h0000_00FF},  // R4 tag set while locked
    '{1'b1, 4'd2, 32'h0000_0000},  // R4
    '{1'b0, 4'd3, 32'hC5AC_CE55},  // R2 unlock
    '{1'b1, 4'd4, 32'h0000_0001},  // R9 unlocked status
    '{1'b0, 4'd1, 32'h0000_00A5},  // R5
    '{1'b1, 4'd2, 32'h0000_00A5},  // R5
    '{1'b0, 4'd1, 32'h0000_0012},  // R5 zero bits keep value
    '{1'b1, 4'd2, 32'h0000_00B7},  // R5
    '{1'b0, 4'd2, 32'h0000_0005},  // R6
    '{1'b1, 4'd2, 32'h0000_00B2},  // R6
    '{1'b1, 4'd1, 32'h0000_00FF},  // R7
    '{1'b0, 4'd2, 32'hFFFF_FF00},  // R8 upper bits ignored
    '{1'b1, 4'd2, 32'h0000_00B2},  // R8
    '{1'b0, 4'd0, 32'hDEAD_BEEF},  // R12
    '{1'b1, 4'd0, 32'hDEAD_BEEF},  // R12
    '{1'b1, 4'd3, 32'h0000_0000},  // R10 key reads zero
    '{1'b0, 4'd4, 32'hFFFF_FFFF},  // R10 status write ignored
    '{1'b1, 4'd4, 32'h0000_0001},  // R10
    '{1'b0, 4'd3, 32'hC5AC_CE54},  // R3 near-miss key relocks
    '{1'b1, 4'd4, 32'h0000_0003},  // R3
    '{1'b0, 4'd2, 32'h0000_00FF},  // R4 tag clear while locked
    '{1'b1, 4'd2, 32'h0000_00B2},  // R4
    '{1'b0, 4'd0, 32'h0000_0000},  // R4 scratch write while locked
    '{1'b1, 4'd0, 32'hDEAD_BEEF},  // R4
    '{1'b0, 4'd7, 32'hFFFF_FFFF},  // R11 unmapped write
    '{1'b1, 4'd7, 32'h0000_0000},  // R11
    '{1'b0, 4'd3, 32'hC5AC_CE55},  // R10 key usable while locked
    '{1'b1, 4'd0, 32'hDEAD_BEEF}   // R12 scratch kept
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [31:0]       rd_data;
  logic              locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dbglk_unit #(.ADDR_W(ADDR_W)) u_dbglk_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .locked(locked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample a quarter period later, then pass the rising edge
  task automatic step(input logic rd, input logic [3:0] a, input logic [31:0] d,
                      input string req);
    @(negedge clk);
    addr = a; rd_en = rd; wr_en = !rd; wr_data = rd ? 32'h0 : d;
    #(PERIOD/4);
    if (rd) check(req, rd_data, d);
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 locked at reset", {31'b0, locked}, 32'h1);
    rst_n = 1'b1;
    step(1'b1, 4'd2, 32'h0, "R1 tags zero");
    step(1'b1, 4'd0, 32'h0, "R1 scratch zero");

    for (int i = 0; i < NVEC; i++)
      step(VEC[i].rd, VEC[i].a, VEC[i].d, $sformatf("vector %0d", i));

    // R2: protected write in the cycle right after the unlocking key write
    step(1'b0, 4'd3, 32'h0000_0000, "");
    step(1'b0, 4'd3, 32'hC5AC_CE55, "");
    step(1'b0, 4'd0, 32'h5A5A_A5A5, "");
    step(1'b1, 4'd0, 32'h5A5A_A5A5, "R2 write right after unlock");
    #1;
    check("R2 locked pin low", {31'b0, locked}, 32'h0);

    // R3: lock then immediate protected write is dropped
    step(1'b0, 4'd3, 32'h0000_0001, "");
    step(1'b0, 4'd0, 32'h1111_1111, "");
    step(1'b1, 4'd0, 32'h5A5A_A5A5, "R3 write right after relock dropped");

    // R11: rd_en low gives zero even on a live address
    @(negedge clk);
    addr = 4'd1; rd_en = 1'b0;
    #(PERIOD/4);
    check("R11 idle read zero", rd_data, 32'h0);

    // R1: reset in mid-run restores lock, tags, scratch
    step(1'b0, 4'd3, 32'hC5AC_CE55, "");
    step(1'b0, 4'd1, 32'h0000_00FF, "");
    @(negedge clk);
    rst_n = 1'b0;
    #(PERIOD/4);
    check("R1 relocked by reset", {31'b0, locked}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'd2, 32'h0, "R1 tags cleared by reset");
    step(1'b1, 4'd0, 32'h0, "R1 scratch cleared by reset");
    step(1'b1, 4'd4, 32'h3, "R1 status after reset");

    done = 1'b1;
    finish_run();
  end
endmodule